// File: doc/BRIEF.md
# Threshold Coincidence Trigger

This block decides, once per clock, whether the detector signals seen at that moment form an event worth recording. Each of four channels has two comparator outputs, one for a low threshold and one for a higher threshold. Two channels belong to the local unit and two to an optional attached unit. A one-byte condition word selects the rule. The rule can ask for a minimum number of channels over the low threshold, or for a number of channels over the high threshold combined with further low-threshold channels. The two parts can be joined by AND or by OR. The condition word can also bring in an external trigger input, or switch the block into a calibration mode.

A channel that crosses the high threshold has also crossed the low one, so it is counted as a low-threshold channel. In AND rules, however, a channel already used to meet the high count cannot also supply one of the extra low channels. When the chosen rule becomes true, the block emits a one-cycle trigger pulse. In the same clock edge it captures a 16-bit pattern that records which comparators were active, the external trigger, the unit's role, the presence of the attached unit, four comparator level flags and the calibration flag. The pattern stays unchanged until the next trigger, so downstream capture logic can read it at leisure.

Top module: `coinc_trigger`

## Requirements
- R1: While reset is asserted, and on the first clock after reset, `trigPulse` is 0 and `trigPattern` is all zeros.
- R2: With condition bits 7..3 all 0 and bits 2..0 equal to L (1 to 4), the trigger fires when at least L channels are over the low threshold. A channel whose high input is set counts as over the low threshold even if its low input is clear.
- R3: With bits 5..3 equal to H (1 to 4) and bit 2 clear, the trigger fires when at least H channels are over the high threshold and at least H+L channels are over the low threshold, where L is bits 1..0. Because the count is H+L, a high channel is never reused as one of the L other low channels.
- R4: With bits 5..3 equal to H (1 to 4) and bit 2 set, the trigger fires when at least H channels are over the high threshold or at least (bits 1..0)+1 channels are over the low threshold.
- R5: With bit 6 set and bits 5..0 zero, only `extTrig` fires the trigger. With bit 6 set and bits 5..0 nonzero, either `extTrig` or the threshold rule fires it.
- R6: With bit 7 set (calibration mode), bits 6..0 are ignored and the trigger fires on `extTrig` alone.
- R7: When `slavePresent` is 0, the inputs of channels 2 and 3 are treated as 0. They neither count towards any rule nor appear in the pattern.
- R8: `trigPulse` goes high one clock after the first cycle in which the selected rule is true, and it stays high for exactly one cycle. A rule that stays true does not fire again until it has been false for at least one cycle.
- R9: The pattern's low byte holds the masked comparator inputs sampled in the firing cycle. Bit 2c is channel c's low input and bit 2c+1 is its high input, for c = 0..3. Channels 0 and 1 are the local unit's first and second channels, and channels 2 and 3 are the attached unit's.
- R10: The pattern's high byte, sampled in the firing cycle, holds `extTrig` in bit 8, `isMaster` in bit 9 and `slavePresent` in bit 10. Bits 11..14 hold `cmpLevel[0..3]` and bit 15 holds condition bit 7. The whole pattern holds its value in every cycle without a pulse.
- R11: A condition byte of 0x00 never fires. A high count field of 5 to 7 can never be met by the high count alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| condByte | input | 8 | Trigger condition word |
| thrLo | input | 4 | Low-threshold comparator outputs, one per channel |
| thrHi | input | 4 | High-threshold comparator outputs, one per channel |
| slavePresent | input | 1 | Attached unit present; when 0, channels 2 and 3 are masked |
| isMaster | input | 1 | This unit acts as master (recorded in the pattern) |
| extTrig | input | 1 | External trigger input |
| cmpLevel | input | 4 | Comparator level flags recorded in the pattern |
| trigPulse | output | 1 | One-cycle trigger pulse |
| trigPattern | output | 16 | Pattern captured at the last trigger |

## Verification
The hardest cases to reach are the AND rules at their boundary. There, the high count is met and the total low count falls exactly one short of H+L, because a high channel would otherwise be counted twice. Random inputs hit this only now and then, so directed steps set up a single channel with both inputs high under a "one high and one other low" rule. They then add a second low channel and check that the trigger fires. The random phase keeps each condition byte for several cycles and makes high inputs sparser than low ones. This exercises both the rising-edge rule and the window just below each threshold count.

// File: rtl/coinc_trig_pkg.sv
package coinc_trig_pkg;

  // Decoded form of the condition word
  typedef enum logic [2:0] {
    CM_IDLE,   // no threshold rule selected
    CM_LOW,    // low-count only
    CM_AND,    // high count AND other lows
    CM_OR,     // high count OR lows
    CM_CAL     // calibration: external input only
  } condMode_t;

  // Strobes handed from control to datapath
  typedef struct packed {
    logic latchPattern;  // capture the pattern this edge
    logic calFlag;       // calibration bit to record
  } trigStrobes_t;

  // Fixed field positions inside the condition word
  localparam int COND_CAL_BIT = 7;
  localparam int COND_EXT_BIT = 6;
  localparam int COND_OR_BIT  = 2;

  // Width of the high byte of the pattern
  localparam int STATUS_W = 8;

endpackage

// File: rtl/coinc_pop_count.sv
module coinc_pop_count #(
  parameter int N     = 4,
  parameter int CNT_W = $clog2(N + 1)
) (
  input  logic [N-1:0]     bits,
  output logic [CNT_W-1:0] count
);

  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++) begin
      count = count + CNT_W'(bits[i]);
    end
  end

endmodule

// File: rtl/coinc_trig_datapath.sv
module coinc_trig_datapath
  import coinc_trig_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = $clog2(NUM_CH + 1),
  parameter int PAT_W  = 2 * NUM_CH + STATUS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] thrLo,
  input  logic [NUM_CH-1:0] thrHi,
  input  logic              slavePresent,
  input  logic              isMaster,
  input  logic              extTrig,
  input  logic [3:0]        cmpLevel,
  input  trigStrobes_t      strobes,
  output logic [CNT_W-1:0]  hiCount,
  output logic [CNT_W-1:0]  loCount,
  output logic [PAT_W-1:0]  trigPattern
);

  localparam int LOCAL_CH = NUM_CH / 2;
  localparam int LB       = 2 * NUM_CH;

  logic [NUM_CH-1:0] chMask;
  logic [NUM_CH-1:0] loMasked;
  logic [NUM_CH-1:0] hiMasked;
  logic [NUM_CH-1:0] loEffective;
  logic [PAT_W-1:0]  nextPattern;

  // Local channels always pass; attached-unit channels need slavePresent
  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      if (c < LOCAL_CH) begin : g_local
        assign chMask[c] = 1'b1;
      end else begin : g_remote
        assign chMask[c] = slavePresent;
      end
      assign loMasked[c]          = thrLo[c] & chMask[c];
      assign hiMasked[c]          = thrHi[c] & chMask[c];
      // over the high level implies over the low level
      assign loEffective[c]       = loMasked[c] | hiMasked[c];
      assign nextPattern[2*c]     = loMasked[c];
      assign nextPattern[2*c + 1] = hiMasked[c];
    end
  endgenerate

  assign nextPattern[LB]         = extTrig;
  assign nextPattern[LB+1]       = isMaster;
  assign nextPattern[LB+2]       = slavePresent;
  assign nextPattern[LB+6:LB+3]  = cmpLevel;
  assign nextPattern[LB+7]       = strobes.calFlag;

  coinc_pop_count #(.N(NUM_CH), .CNT_W(CNT_W)) u_hiPop (
    .bits  (hiMasked),
    .count (hiCount)
  );

  coinc_pop_count #(.N(NUM_CH), .CNT_W(CNT_W)) u_loPop (
    .bits  (loEffective),
    .count (loCount)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trigPattern <= '0;
    end else if (strobes.latchPattern) begin
      trigPattern <= nextPattern;
    end
  end

endmodule

// File: rtl/coinc_trig_ctrl.sv
module coinc_trig_ctrl
  import coinc_trig_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = $clog2(NUM_CH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       condByte,
  input  logic [CNT_W-1:0] hiCount,
  input  logic [CNT_W-1:0] loCount,
  input  logic             extTrig,
  output trigStrobes_t     strobes,
  output logic             trigPulse
);

  // Compare width wide enough for count fields and H+L sums
  localparam int CMP_W = ((CNT_W > 4) ? CNT_W : 4) + 1;

  condMode_t        mode;
  logic [CMP_W-1:0] hNeed;
  logic [CMP_W-1:0] lowField;
  logic [CMP_W-1:0] orLowNeed;
  logic [CMP_W-1:0] andLowNeed;
  logic [CMP_W-1:0] hiWide;
  logic [CMP_W-1:0] loWide;
  logic             thrMet;
  logic             extSel;
  logic             fireNow;
  logic             firePrev;

  assign hNeed      = CMP_W'(condByte[5:3]);
  assign lowField   = CMP_W'(condByte[2:0]);
  assign orLowNeed  = CMP_W'(condByte[1:0]) + CMP_W'(1);
  assign andLowNeed = hNeed + lowField;
  assign hiWide     = CMP_W'(hiCount);
  assign loWide     = CMP_W'(loCount);
  assign extSel     = condByte[COND_EXT_BIT];

  // Condition word decode
  always_comb begin
    if (condByte[COND_CAL_BIT]) begin
      mode = CM_CAL;
    end else if (condByte[5:0] == 6'd0) begin
      mode = CM_IDLE;
    end else if (condByte[5:3] == 3'd0) begin
      mode = CM_LOW;
    end else if (condByte[COND_OR_BIT]) begin
      mode = CM_OR;
    end else begin
      mode = CM_AND;
    end
  end

  // Threshold rule evaluation
  always_comb begin
    unique case (mode)
      CM_LOW:  thrMet = (loWide >= lowField);
      CM_AND:  thrMet = (hiWide >= hNeed) && (loWide >= andLowNeed);
      CM_OR:   thrMet = (hiWide >= hNeed) || (loWide >= orLowNeed);
      default: thrMet = 1'b0;
    endcase
  end

  always_comb begin
    if (mode == CM_CAL) begin
      fireNow = extTrig;
    end else begin
      fireNow = thrMet | (extSel & extTrig);
    end
  end

  assign strobes.latchPattern = fireNow & ~firePrev;
  assign strobes.calFlag      = condByte[COND_CAL_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      firePrev  <= 1'b0;
      trigPulse <= 1'b0;
    end else begin
      firePrev  <= fireNow;
      trigPulse <= strobes.latchPattern;
    end
  end

endmodule

// File: rtl/coinc_trigger.sv
module coinc_trigger
  import coinc_trig_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = $clog2(NUM_CH + 1),
  parameter int PAT_W  = 2 * NUM_CH + STATUS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        condByte,
  input  logic [NUM_CH-1:0] thrLo,
  input  logic [NUM_CH-1:0] thrHi,
  input  logic              slavePresent,
  input  logic              isMaster,
  input  logic              extTrig,
  input  logic [3:0]        cmpLevel,
  output logic              trigPulse,
  output logic [PAT_W-1:0]  trigPattern
);

  trigStrobes_t     strobes;
  logic [CNT_W-1:0] hiCount;
  logic [CNT_W-1:0] loCount;

  coinc_trig_ctrl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .condByte  (condByte),
    .hiCount   (hiCount),
    .loCount   (loCount),
    .extTrig   (extTrig),
    .strobes   (strobes),
    .trigPulse (trigPulse)
  );

  coinc_trig_datapath #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .PAT_W(PAT_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .thrLo        (thrLo),
    .thrHi        (thrHi),
    .slavePresent (slavePresent),
    .isMaster     (isMaster),
    .extTrig      (extTrig),
    .cmpLevel     (cmpLevel),
    .strobes      (strobes),
    .hiCount      (hiCount),
    .loCount      (loCount),
    .trigPattern  (trigPattern)
  );

endmodule

// File: rtl/coinc_trigger_chk.sv
module coinc_trigger_chk #(
  parameter int NUM_CH = 4,
  parameter int PAT_W  = 2 * NUM_CH + 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [7:0]        condByte,
  input logic              extTrig,
  input logic              trigPulse,
  input logic [PAT_W-1:0]  trigPattern
);

  localparam int LB = 2 * NUM_CH;

  // R8
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |=> !trigPulse);

  // R10
  pattern_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !trigPulse |-> $stable(trigPattern));

  // R7
  slave_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trigPulse && !trigPattern[LB+2]) |-> (trigPattern[LB-1:NUM_CH] == '0));

  // R6
  cal_ext_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trigPulse && trigPattern[LB+7]) |-> trigPattern[LB]);

  // R11
  idle_cond_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && ($past(condByte) == 8'h00)) |-> !trigPulse);

  // R10
  ext_record_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && trigPulse) |-> (trigPattern[LB] == $past(extTrig)));

endmodule

bind coinc_trigger coinc_trigger_chk #(.NUM_CH(NUM_CH), .PAT_W(PAT_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .condByte    (condByte),
  .extTrig     (extTrig),
  .trigPulse   (trigPulse),
  .trigPattern (trigPattern)
);

// File: tb/coinc_trigger_bench.sv
module coinc_trigger_bench;

  localparam time CLK_HALF = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  condByte = 8'h00;
  logic [3:0]  thrLo = '0;
  logic [3:0]  thrHi = '0;
  logic        slavePresent = 1'b0;
  logic        isMaster = 1'b0;
  logic        extTrig = 1'b0;
  logic [3:0]  cmpLevel = '0;
  logic        trigPulse;
  logic [15:0] trigPattern;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit          mPrev = 0;
  logic [15:0] expPat = '0;

  always #(CLK_HALF) clk = ~clk;

  coinc_trigger u_coinc_trigger (
    .clk          (clk),
    .rstN         (rstN),
    .condByte     (condByte),
    .thrLo        (thrLo),
    .thrHi        (thrHi),
    .slavePresent (slavePresent),
    .isMaster     (isMaster),
    .extTrig      (extTrig),
    .cmpLevel     (cmpLevel),
    .trigPulse    (trigPulse),
    .trigPattern  (trigPattern)
  );

  function automatic bit modelFire(input logic [7:0] c, input logic [3:0] lo,
                                   input logic [3:0] hi, input bit sp, input bit ext);
    logic [3:0] m;
    int hc, lc, h;
    bit thr;
    m  = sp ? 4'hF : 4'h3;
    hc = $countones(hi & m);
    lc = $countones((lo | hi) & m);
    h  = int'(c[5:3]);
    if (c[7]) return ext;
    if (c[5:0] == 6'd0)  thr = 0;
    else if (h == 0)     thr = (lc >= int'(c[2:0]));
    else if (c[2])       thr = (hc >= h) || (lc >= int'(c[1:0]) + 1);
    else                 thr = (hc >= h) && (lc >= h + int'(c[2:0]));
    return thr || (c[6] && ext);
  endfunction

  function automatic logic [15:0] modelPat(input logic [7:0] c, input logic [3:0] lo,
                                           input logic [3:0] hi, input bit sp, input bit im,
                                           input bit ext, input logic [3:0] lvl);
    logic [15:0] p;
    logic [3:0] m;
    m = sp ? 4'hF : 4'h3;
    for (int i = 0; i < 4; i++) begin
      p[2*i]   = lo[i] & m[i];
      p[2*i+1] = hi[i] & m[i];
    end
    p[8]     = ext;
    p[9]     = im;
    p[10]    = sp;
    p[14:11] = lvl;
    p[15]    = c[7];
    return p;
  endfunction

  task automatic checkVal(input string tag, input string what,
                          input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Drive at a falling edge, wait one clock, check at the next falling edge
  task automatic step(input logic [7:0] c, input logic [3:0] lo, input logic [3:0] hi,
                      input bit sp, input bit im, input bit ext, input logic [3:0] lvl,
                      input string tag);
    bit f, p;
    condByte = c; thrLo = lo; thrHi = hi; slavePresent = sp;
    isMaster = im; extTrig = ext; cmpLevel = lvl;
    f = modelFire(c, lo, hi, sp, ext);
    p = f && !mPrev;
    if (p) expPat = modelPat(c, lo, hi, sp, im, ext, lvl);
    mPrev = f;
    @(negedge clk);
    checkVal(tag, "pulse", {15'd0, trigPulse}, {15'd0, p});
    checkVal("R9 R10", "pattern", trigPattern, expPat);
  endtask

  function automatic string tagFor(input logic [7:0] c);
    if (c[7]) return "R6";
    if (c[6]) return "R5";
    if (c[5:0] == 0) return "R11";
    if (c[5:3] == 0) return "R2";
    if (c[2]) return "R4";
    return "R3";
  endfunction

  initial begin
    #(CLK_HALF * 2 * 300000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] c;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state while inputs would fire
    condByte = 8'h01; thrLo = 4'hF; extTrig = 1'b1;
    @(negedge clk);
    checkVal("R1", "pulse in reset", {15'd0, trigPulse}, 16'd0);
    checkVal("R1", "pattern in reset", trigPattern, 16'd0);
    condByte = 8'h00; thrLo = '0; extTrig = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R1", "pulse after reset", {15'd0, trigPulse}, 16'd0);
    checkVal("R1", "pattern after reset", trigPattern, 16'd0);

    // R2: high input alone counts as low
    step(8'h02, 4'b0000, 4'b0101, 1, 1, 0, 4'h5, "R2");
    step(8'h02, 4'b0000, 4'b0000, 1, 1, 0, 4'h5, "R2");
    step(8'h03, 4'b0011, 4'b0000, 1, 0, 0, 4'h0, "R2");
    // R3: a high channel is not reused as the other low
    step(8'h09, 4'b0001, 4'b0001, 1, 1, 0, 4'h0, "R3");
    step(8'h09, 4'b0011, 4'b0001, 1, 1, 0, 4'h0, "R3");
    step(8'h00, 4'b0000, 4'b0000, 1, 1, 0, 4'h0, "R11");
    step(8'h12, 4'b1111, 4'b0011, 1, 1, 0, 4'h0, "R3");
    step(8'h00, 4'b0000, 4'b0000, 1, 1, 0, 4'h0, "R11");
    step(8'h12, 4'b0111, 4'b0011, 1, 1, 0, 4'h0, "R3");
    // R4: OR rule satisfied by a single low
    step(8'h14, 4'b0100, 4'b0000, 1, 0, 0, 4'h0, "R4");
    step(8'h00, 4'b0000, 4'b0000, 1, 0, 0, 4'h0, "R11");
    step(8'h15, 4'b0100, 4'b0000, 1, 0, 0, 4'h0, "R4");
    // R7: attached channels masked when absent
    step(8'h01, 4'b1100, 4'b1100, 0, 1, 0, 4'h0, "R7");
    step(8'h01, 4'b1101, 4'b1100, 0, 1, 0, 4'h0, "R7");
    step(8'h00, 4'b0000, 4'b0000, 0, 1, 0, 4'h0, "R11");
    // R5: external only, then external or threshold
    step(8'h40, 4'b1111, 4'b1111, 1, 1, 0, 4'h0, "R5");
    step(8'h40, 4'b0000, 4'b0000, 1, 1, 1, 4'h0, "R5");
    step(8'h00, 4'b0000, 4'b0000, 1, 1, 0, 4'h0, "R11");
    step(8'h41, 4'b0010, 4'b0000, 1, 1, 0, 4'h0, "R5");
    // R6: calibration ignores thresholds, fires on external input
    step(8'hBF, 4'b1111, 4'b1111, 1, 1, 0, 4'hA, "R6");
    step(8'h81, 4'b1111, 4'b1111, 1, 1, 1, 4'hA, "R6");
    // R8: held condition gives one pulse only
    step(8'h08, 4'b0000, 4'b0001, 1, 1, 0, 4'h3, "R8");
    step(8'h08, 4'b0000, 4'b0001, 1, 1, 0, 4'h3, "R8");
    step(8'h08, 4'b0000, 4'b0011, 1, 1, 0, 4'h3, "R8");
    step(8'h08, 4'b0000, 4'b0000, 1, 1, 0, 4'h3, "R8");
    step(8'h08, 4'b0000, 4'b1000, 1, 0, 1, 4'hC, "R8");
    // R11: zero condition and unreachable high count
    step(8'h00, 4'b1111, 4'b1111, 1, 1, 1, 4'h0, "R11");
    step(8'h28, 4'b1111, 4'b1111, 1, 1, 1, 4'h0, "R11");

    // Random phase
    c = 8'h08;
    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 6 == 0) begin
        c[7]   = ($urandom % 16 == 0);
        c[6]   = ($urandom % 4 == 0);
        c[5:3] = 3'($urandom % 5);
        c[2:0] = 3'($urandom % 8);
      end
      step(c, 4'($urandom), 4'($urandom & $urandom), bit'($urandom % 3 != 0),
           bit'($urandom), bit'($urandom % 4 == 0), 4'($urandom), tagFor(c));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule